// File: doc/BRIEF.md
# Multi-Cycle Control Sequencer

This block is the control state machine of a 16-bit processor whose instructions take several clock cycles each. It captures the fetched instruction word into an internal instruction register, then steps through a fixed set of eight states: fetch, decode, ALU execute, write-back, memory read, memory write, jump and halt. In each state it drives the enables for the register file, the ALU, the memory port and the instruction pointer. Every output is a function of registered state only, which makes it a strict Moore machine. The register file, ALU, flag register, instruction pointer and condition evaluation all sit in the datapath. The sequencer only tells the datapath what to do and when.

An instruction word is split into a 4-bit opcode in bits 15:12, a 4-bit field A in bits 11:8, and either a 4-bit field B in bits 7:4 or an 8-bit immediate or offset in bits 7:0. Field A always names the destination register or address register. For a jump, field A carries the condition code. The datapath evaluates that condition against its flags and returns a single branch-taken bit while the sequencer is in decode.

The opcodes are:

| Opcode | Operation | Opcode | Operation |
|---|---|---|---|
| 0 | no operation | 7 | subtract immediate |
| 1 | halt | 8 | XOR |
| 2 | load | 9 | AND |
| 3 | store | 10 | OR |
| 4 | add | 11 | relative jump |
| 5 | subtract | 12 to 15 | reserved, treated as no operation |
| 6 | add immediate | | |

The states and their transitions are:

| State | Code | Next state |
|---|---|---|
| FETCH | 0 | DECODE |
| DECODE | 1 | chosen by the opcode: JUMP, MEMRD, MEMWR, ALU, HALT or FETCH |
| ALU | 2 | WBACK |
| WBACK | 3 | FETCH |
| MEMRD | 4 | FETCH |
| MEMWR | 5 | FETCH |
| JUMP | 6 | FETCH |
| HALT | 7 | HALT, left only through reset |

Top module: `mc_ctrl_seq`

## Requirements
- R1: While reset (active-low, asynchronous) is low, and on the first cycle after it is released, the state code is 0 (FETCH). None of rf_we, mem_wr, flag_we, ip_rel_we or halted is asserted. The reset state is restored from HALT.
- R2: In FETCH the outputs ir_load, ip_inc and mem_rd are 1, mem_addr_sel is 0 (instruction pointer) and no write strobe is active. The instruction input is latched at the end of FETCH, and the next state is always DECODE (code 1). In DECODE no strobe is active.
- R3: Register ALU opcodes (4 add, 5 subtract, 8 XOR, 9 AND, 10 OR) go FETCH, DECODE, ALU (code 2), WBACK (code 3), FETCH. In ALU, alu_op is 0 for add, 1 for subtract, 2 for XOR, 3 for AND and 4 for OR, and alu_src_imm is 0.
- R4: Immediate opcodes 6 (add) and 7 (subtract) follow the same path with alu_src_imm = 1 in ALU. The outputs are alu_op 0 or 1 and ir_sext = bits 7:0 of the instruction sign-extended to 16 bits.
- R5: flag_we (bit 2 sign, bit 1 overflow, bit 0 zero) is 3'b111 for add and subtract, and 3'b101 for XOR, AND and OR. It is asserted only in ALU. In WBACK the outputs are rf_we = 1, rf_waddr = field A and rf_wsrc_mem = 0.
- R6: Load (opcode 2) goes FETCH, DECODE, MEMRD (code 4), FETCH. MEMRD asserts mem_rd, rf_we and rf_wsrc_mem, with mem_addr_sel = 2 (read port B, field B) and rf_waddr = field A.
- R7: Store (opcode 3) goes FETCH, DECODE, MEMWR (code 5), FETCH. MEMWR asserts mem_wr with mem_addr_sel = 1 (read port A, field A; the data comes from port B) and never asserts rf_we.
- R8: A jump (opcode 11) goes FETCH, DECODE, JUMP (code 6), FETCH. In JUMP, ip_rel_we equals br_taken as sampled at the end of DECODE, and ir_sext carries the offset sign-extended. The value of br_taken during JUMP has no effect.
- R9: No operation (opcode 0) and the reserved opcodes 12 to 15 return from DECODE to FETCH without asserting any write strobe.
- R10: Halt (opcode 1) enters HALT (code 7). In HALT, halted = 1 and every other strobe is 0, whatever the instruction and branch inputs are, until reset.
- R11: The outputs change only at clock edges. A change of instr or br_taken within a cycle leaves every output unchanged in that cycle, and instr has no effect outside FETCH.
- R12: rf_rd_a, rf_waddr and jcond present field A, and rf_rd_b presents field B, of the instruction latched in the last FETCH. They hold stable in every state other than FETCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| instr_i | input | 16 | fetched instruction word, valid in FETCH |
| br_taken_i | input | 1 | condition result from the datapath, sampled in DECODE |
| state_o | output | 3 | current state code |
| ir_load_o | output | 1 | instruction capture strobe |
| ip_inc_o | output | 1 | advance the instruction pointer by one word |
| ip_rel_we_o | output | 1 | add ir_sext_o to the instruction pointer |
| ir_sext_o | output | 16 | sign-extended immediate or offset |
| jcond_o | output | 4 | jump condition code for the datapath |
| mem_rd_o | output | 1 | memory read strobe |
| mem_wr_o | output | 1 | memory write strobe |
| mem_addr_sel_o | output | 2 | memory address source: 0 instruction pointer, 1 port A, 2 port B |
| rf_rd_a_o | output | 4 | register read port A address |
| rf_rd_b_o | output | 4 | register read port B address |
| rf_we_o | output | 1 | register write strobe |
| rf_waddr_o | output | 4 | register write address |
| rf_wsrc_mem_o | output | 1 | write data from memory (1) or the ALU result (0) |
| alu_op_o | output | 3 | ALU operation code |
| alu_src_imm_o | output | 1 | ALU second operand from the immediate |
| flag_we_o | output | 3 | flag write enables {sign, overflow, zero} |
| halted_o | output | 1 | sequencer is halted |

## Verification
The bench releases reset and then takes its samples 2 ns after each rising edge. The fetch outputs are due at the sample that follows the release, the decode outputs one sample later, and the execute, memory, jump or halt outputs two samples later. A write-back is due three samples after fetch, and the next fetch follows at once. Each scenario task samples exactly those points. It changes instr or br_taken only after it has sampled, and it rechecks after a mid-cycle change to confirm that nothing moved before the next edge. The branch bit is driven during DECODE and checked one edge later in JUMP. The halt scenario keeps checking across many cycles of changing inputs before it applies reset.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_ALU    = 3'd2,
        ST_WBACK  = 3'd3,
        ST_MEMRD  = 3'd4,
        ST_MEMWR  = 3'd5,
        ST_JUMP   = 3'd6,
        ST_HALT   = 3'd7
    } seq_state_e;

    typedef enum logic [2:0] {
        CL_NONE  = 3'd0,
        CL_HALT  = 3'd1,
        CL_LOAD  = 3'd2,
        CL_STORE = 3'd3,
        CL_ALU   = 3'd4,
        CL_JUMP  = 3'd5
    } instr_class_e;

    localparam logic [2:0] ALU_ADD = 3'd0;
    localparam logic [2:0] ALU_SUB = 3'd1;
    localparam logic [2:0] ALU_XOR = 3'd2;
    localparam logic [2:0] ALU_AND = 3'd3;
    localparam logic [2:0] ALU_OR  = 3'd4;

    localparam logic [1:0] ADR_IP    = 2'd0;
    localparam logic [1:0] ADR_PORTA = 2'd1;
    localparam logic [1:0] ADR_PORTB = 2'd2;

    localparam logic [2:0] FLAGS_ARITH = 3'b111;
    localparam logic [2:0] FLAGS_LOGIC = 3'b101;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_HLT   = 4'd1;
    localparam logic [3:0] OP_LOAD  = 4'd2;
    localparam logic [3:0] OP_STORE = 4'd3;
    localparam logic [3:0] OP_ADD   = 4'd4;
    localparam logic [3:0] OP_SUB   = 4'd5;
    localparam logic [3:0] OP_ADDI  = 4'd6;
    localparam logic [3:0] OP_SUBI  = 4'd7;
    localparam logic [3:0] OP_XOR   = 4'd8;
    localparam logic [3:0] OP_AND   = 4'd9;
    localparam logic [3:0] OP_OR    = 4'd10;
    localparam logic [3:0] OP_JUMP  = 4'd11;

    typedef struct packed {
        instr_class_e cls;
        logic [2:0]   alu_op;
        logic         use_imm;
        logic         arith;
    } dec_t;

endpackage

// File: rtl/mc_seq_ir.sv
module mc_seq_ir #(
    parameter int IW   = 16,
    parameter int RW   = 4,
    parameter int IMMW = 8,
    parameter int XW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [IW-1:0]   instr_i,
    input  logic            take_en_i,
    input  logic            br_taken_i,
    output logic [IW-RW-IMMW-1:0] opcode_o,
    output logic [RW-1:0]   fa_o,
    output logic [RW-1:0]   fb_o,
    output logic [XW-1:0]   sext_o,
    output logic            take_o
);
    localparam int OPW   = IW - RW - IMMW;
    localparam int FA_HI = IW - OPW - 1;
    localparam int FB_HI = IMMW - 1;

    logic [IW-1:0] ir_q;
    logic          take_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (load_i) begin
            ir_q <= instr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q <= 1'b0;
        end else if (take_en_i) begin
            take_q <= br_taken_i;
        end
    end

    assign opcode_o = ir_q[IW-1 -: OPW];
    assign fa_o     = ir_q[FA_HI -: RW];
    assign fb_o     = ir_q[FB_HI -: RW];
    assign take_o   = take_q;

    generate
        if (XW > IMMW) begin : g_ext
            assign sext_o = {{(XW-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
        end else begin : g_trunc
            assign sext_o = ir_q[XW-1:0];
        end
    endgenerate

endmodule

// File: rtl/mc_seq_decode.sv
module mc_seq_decode
    import mc_seq_pkg::*;
#(
    parameter int OPW = 4
) (
    input  logic [OPW-1:0] opcode_i,
    output dec_t           dec_o
);
    logic [3:0] opc;

    generate
        if (OPW >= 4) begin : g_wide
            assign opc = opcode_i[3:0];
        end else begin : g_narrow
            assign opc = {{(4-OPW){1'b0}}, opcode_i};
        end
    endgenerate

    always_comb begin
        dec_o = '{cls: CL_NONE, alu_op: ALU_ADD, use_imm: 1'b0, arith: 1'b0};
        case (opc)
            OP_HLT:   dec_o.cls = CL_HALT;
            OP_LOAD:  dec_o.cls = CL_LOAD;
            OP_STORE: dec_o.cls = CL_STORE;
            OP_JUMP:  dec_o.cls = CL_JUMP;
            OP_ADD: begin
                dec_o.cls    = CL_ALU;
                dec_o.alu_op = ALU_ADD;
                dec_o.arith  = 1'b1;
            end
            OP_SUB: begin
                dec_o.cls    = CL_ALU;
                dec_o.alu_op = ALU_SUB;
                dec_o.arith  = 1'b1;
            end
            OP_ADDI: begin
                dec_o.cls     = CL_ALU;
                dec_o.alu_op  = ALU_ADD;
                dec_o.arith   = 1'b1;
                dec_o.use_imm = 1'b1;
            end
            OP_SUBI: begin
                dec_o.cls     = CL_ALU;
                dec_o.alu_op  = ALU_SUB;
                dec_o.arith   = 1'b1;
                dec_o.use_imm = 1'b1;
            end
            OP_XOR: begin
                dec_o.cls    = CL_ALU;
                dec_o.alu_op = ALU_XOR;
            end
            OP_AND: begin
                dec_o.cls    = CL_ALU;
                dec_o.alu_op = ALU_AND;
            end
            OP_OR: begin
                dec_o.cls    = CL_ALU;
                dec_o.alu_op = ALU_OR;
            end
            default: dec_o.cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/mc_seq_next.sv
module mc_seq_next
    import mc_seq_pkg::*;
(
    input  seq_state_e   state_i,
    input  instr_class_e cls_i,
    output seq_state_e   next_o
);
    always_comb begin
        next_o = ST_FETCH;
        unique case (state_i)
            ST_FETCH:  next_o = ST_DECODE;
            ST_DECODE: begin
                case (cls_i)
                    CL_HALT:  next_o = ST_HALT;
                    CL_LOAD:  next_o = ST_MEMRD;
                    CL_STORE: next_o = ST_MEMWR;
                    CL_ALU:   next_o = ST_ALU;
                    CL_JUMP:  next_o = ST_JUMP;
                    default:  next_o = ST_FETCH;
                endcase
            end
            ST_ALU:    next_o = ST_WBACK;
            ST_WBACK:  next_o = ST_FETCH;
            ST_MEMRD:  next_o = ST_FETCH;
            ST_MEMWR:  next_o = ST_FETCH;
            ST_JUMP:   next_o = ST_FETCH;
            ST_HALT:   next_o = ST_HALT;
        endcase
    end

endmodule

// File: rtl/mc_seq_outputs.sv
module mc_seq_outputs
    import mc_seq_pkg::*;
#(
    parameter int RW = 4
) (
    input  seq_state_e  state_i,
    input  logic [2:0]  alu_op_i,
    input  logic        use_imm_i,
    input  logic        arith_i,
    input  logic        take_i,
    input  logic [RW-1:0] fa_i,
    input  logic [RW-1:0] fb_i,
    output logic        ir_load_o,
    output logic        ip_inc_o,
    output logic        ip_rel_we_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  mem_addr_sel_o,
    output logic [RW-1:0] rf_rd_a_o,
    output logic [RW-1:0] rf_rd_b_o,
    output logic        rf_we_o,
    output logic [RW-1:0] rf_waddr_o,
    output logic        rf_wsrc_mem_o,
    output logic [2:0]  alu_op_o,
    output logic        alu_src_imm_o,
    output logic [2:0]  flag_we_o,
    output logic        halted_o
);
    assign rf_rd_a_o  = fa_i;
    assign rf_rd_b_o  = fb_i;
    assign rf_waddr_o = fa_i;

    always_comb begin
        ir_load_o      = 1'b0;
        ip_inc_o       = 1'b0;
        ip_rel_we_o    = 1'b0;
        mem_rd_o       = 1'b0;
        mem_wr_o       = 1'b0;
        mem_addr_sel_o = ADR_IP;
        rf_we_o        = 1'b0;
        rf_wsrc_mem_o  = 1'b0;
        alu_op_o       = ALU_ADD;
        alu_src_imm_o  = 1'b0;
        flag_we_o      = 3'b000;
        halted_o       = 1'b0;
        unique case (state_i)
            ST_FETCH: begin
                ir_load_o      = 1'b1;
                ip_inc_o       = 1'b1;
                mem_rd_o       = 1'b1;
                mem_addr_sel_o = ADR_IP;
            end
            ST_DECODE: begin
            end
            ST_ALU: begin
                alu_op_o      = alu_op_i;
                alu_src_imm_o = use_imm_i;
                flag_we_o     = arith_i ? FLAGS_ARITH : FLAGS_LOGIC;
            end
            ST_WBACK: begin
                rf_we_o = 1'b1;
            end
            ST_MEMRD: begin
                mem_rd_o       = 1'b1;
                mem_addr_sel_o = ADR_PORTB;
                rf_we_o        = 1'b1;
                rf_wsrc_mem_o  = 1'b1;
            end
            ST_MEMWR: begin
                mem_wr_o       = 1'b1;
                mem_addr_sel_o = ADR_PORTA;
            end
            ST_JUMP: begin
                ip_rel_we_o = take_i;
            end
            ST_HALT: begin
                halted_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
    import mc_seq_pkg::*;
#(
    parameter int IW   = 16,
    parameter int RW   = 4,
    parameter int IMMW = 8,
    parameter int XW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   instr_i,
    input  logic            br_taken_i,
    output logic [2:0]      state_o,
    output logic            ir_load_o,
    output logic            ip_inc_o,
    output logic            ip_rel_we_o,
    output logic [XW-1:0]   ir_sext_o,
    output logic [RW-1:0]   jcond_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [1:0]      mem_addr_sel_o,
    output logic [RW-1:0]   rf_rd_a_o,
    output logic [RW-1:0]   rf_rd_b_o,
    output logic            rf_we_o,
    output logic [RW-1:0]   rf_waddr_o,
    output logic            rf_wsrc_mem_o,
    output logic [2:0]      alu_op_o,
    output logic            alu_src_imm_o,
    output logic [2:0]      flag_we_o,
    output logic            halted_o
);
    localparam int OPW = IW - RW - IMMW;

    seq_state_e     state_q;
    seq_state_e     state_d;
    logic [OPW-1:0] opcode;
    logic [RW-1:0]  fa;
    logic [RW-1:0]  fb;
    logic           take;
    dec_t           dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    mc_seq_ir #(.IW(IW), .RW(RW), .IMMW(IMMW), .XW(XW)) u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (state_q == ST_FETCH),
        .instr_i    (instr_i),
        .take_en_i  (state_q == ST_DECODE),
        .br_taken_i (br_taken_i),
        .opcode_o   (opcode),
        .fa_o       (fa),
        .fb_o       (fb),
        .sext_o     (ir_sext_o),
        .take_o     (take)
    );

    mc_seq_decode #(.OPW(OPW)) u_dec (
        .opcode_i (opcode),
        .dec_o    (dec)
    );

    mc_seq_next u_next (
        .state_i (state_q),
        .cls_i   (dec.cls),
        .next_o  (state_d)
    );

    mc_seq_outputs #(.RW(RW)) u_out (
        .state_i        (state_q),
        .alu_op_i       (dec.alu_op),
        .use_imm_i      (dec.use_imm),
        .arith_i        (dec.arith),
        .take_i         (take),
        .fa_i           (fa),
        .fb_i           (fb),
        .ir_load_o      (ir_load_o),
        .ip_inc_o       (ip_inc_o),
        .ip_rel_we_o    (ip_rel_we_o),
        .mem_rd_o       (mem_rd_o),
        .mem_wr_o       (mem_wr_o),
        .mem_addr_sel_o (mem_addr_sel_o),
        .rf_rd_a_o      (rf_rd_a_o),
        .rf_rd_b_o      (rf_rd_b_o),
        .rf_we_o        (rf_we_o),
        .rf_waddr_o     (rf_waddr_o),
        .rf_wsrc_mem_o  (rf_wsrc_mem_o),
        .alu_op_o       (alu_op_o),
        .alu_src_imm_o  (alu_src_imm_o),
        .flag_we_o      (flag_we_o),
        .halted_o       (halted_o)
    );

    assign state_o = state_q;
    assign jcond_o = fa;

endmodule

// File: rtl/mc_ctrl_seq_chk.sv
module mc_ctrl_seq_chk
    import mc_seq_pkg::*;
#(
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          br_taken_i,
    input logic [2:0]    state_o,
    input logic          mem_rd_o,
    input logic          mem_wr_o,
    input logic          rf_we_o,
    input logic [2:0]    flag_we_o,
    input logic          ip_rel_we_o,
    input logic          halted_o,
    input logic [RW-1:0] rf_rd_a_o,
    input logic [RW-1:0] rf_rd_b_o
);
    p_reset_fetch_r1: assert property (@(posedge clk)
        !rst_n |-> (state_o == ST_FETCH && !halted_o && !rf_we_o));

    p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_FETCH) |=> (state_o == ST_DECODE));

    p_mem_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_alu_to_wback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ALU) |=> (state_o == ST_WBACK));

    p_flags_alu_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_o != 3'b000) |-> (state_o == ST_ALU));

    p_store_no_rf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_MEMWR) |-> (mem_wr_o && !rf_we_o));

    p_jump_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_JUMP) |-> (ip_rel_we_o == $past(br_taken_i)));

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HALT) |=> (state_o == ST_HALT && halted_o));

    p_fields_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_FETCH) |=> ($stable(rf_rd_a_o) && $stable(rf_rd_b_o)));

endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk #(.RW(RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_taken_i  (br_taken_i),
    .state_o     (state_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .rf_we_o     (rf_we_o),
    .flag_we_o   (flag_we_o),
    .ip_rel_we_o (ip_rel_we_o),
    .halted_o    (halted_o),
    .rf_rd_a_o   (rf_rd_a_o),
    .rf_rd_b_o   (rf_rd_b_o)
);

// File: tb/mc_ctrl_seq_test.sv
`timescale 1ns/1ps
module mc_ctrl_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [15:0] instr = 16'h0000;
    logic        br_taken = 1'b0;

    logic [2:0]  state;
    logic        ir_load, ip_inc, ip_rel_we, mem_rd, mem_wr, rf_we, rf_wsrc_mem;
    logic        alu_src_imm, halted;
    logic [15:0] ir_sext;
    logic [3:0]  jcond, rf_rd_a, rf_rd_b, rf_waddr;
    logic [1:0]  mem_addr_sel;
    logic [2:0]  alu_op, flag_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mc_ctrl_seq uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .br_taken_i(br_taken),
        .state_o(state), .ir_load_o(ir_load), .ip_inc_o(ip_inc),
        .ip_rel_we_o(ip_rel_we), .ir_sext_o(ir_sext), .jcond_o(jcond),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_sel_o(mem_addr_sel),
        .rf_rd_a_o(rf_rd_a), .rf_rd_b_o(rf_rd_b), .rf_we_o(rf_we),
        .rf_waddr_o(rf_waddr), .rf_wsrc_mem_o(rf_wsrc_mem), .alu_op_o(alu_op),
        .alu_src_imm_o(alu_src_imm), .flag_we_o(flag_we), .halted_o(halted)
    );

    // {ir_load, ip_inc, ip_rel_we, mem_rd, mem_wr, rf_we, wsrc_mem, src_imm, flag_we[2:0], halted}
    wire [11:0] ctl = {ir_load, ip_inc, ip_rel_we, mem_rd, mem_wr, rf_we,
                       rf_wsrc_mem, alu_src_imm, flag_we, halted};

    localparam logic [11:0] CTL_FETCH = 12'hD00;
    localparam logic [11:0] CTL_WBACK = 12'h040;
    localparam logic [11:0] CTL_MEMRD = 12'h160;
    localparam logic [11:0] CTL_MEMWR = 12'h080;
    localparam logic [11:0] CTL_JUMP  = 12'h200;
    localparam logic [11:0] CTL_HALT  = 12'h001;
    localparam logic [11:0] WR_MASK   = 12'h2CF;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_fetch(input string req);
        chk({req, " fetch state"}, 32'(state), 32'd0);
        chk({req, " fetch ctl"}, 32'(ctl), 32'(CTL_FETCH));
        chk({req, " fetch addr_sel"}, 32'(mem_addr_sel), 32'd0);
    endtask

    task automatic expect_decode(input string req, input logic [3:0] a, input logic [3:0] b);
        chk({req, " decode state"}, 32'(state), 32'd1);
        chk({req, " decode ctl"}, 32'(ctl), 32'd0);
        chk({req, " R12 rd_a"}, 32'(rf_rd_a), 32'(a));
        chk({req, " R12 rd_b"}, 32'(rf_rd_b), 32'(b));
    endtask

    // R1: reset state
    task automatic t_reset();
        chk("R1 state in reset", 32'(state), 32'd0);
        chk("R1 no write strobe in reset", 32'(ctl & WR_MASK), 32'd0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        chk("R1 state after release", 32'(state), 32'd0);
        chk("R1 halted after release", 32'(halted), 32'd0);
    endtask

    // R3 R4 R5 R11 R12: ALU instruction path
    task automatic t_alu(input string req, input logic [3:0] opc, input logic [2:0] exp_op,
                         input bit imm, input logic [2:0] fl);
        logic [11:0] snap_ctl;
        logic [2:0]  snap_op;
        logic [11:0] exp_ctl;
        exp_ctl = {8'h00, fl, 1'b0} | (imm ? 12'h010 : 12'h000);
        instr = {opc, 4'h3, 8'hA5};
        expect_fetch({req, " R2"});
        tick();
        instr = 16'h1000;
        expect_decode(req, 4'h3, 4'hA);
        tick();
        chk({req, " R3 alu state"}, 32'(state), 32'd2);
        chk({req, " R3 alu_op"}, 32'(alu_op), 32'(exp_op));
        chk({req, " R5 alu ctl"}, 32'(ctl), 32'(exp_ctl));
        if (imm) chk({req, " R4 sext"}, 32'(ir_sext), 32'h0000FFA5);
        snap_ctl = ctl;
        snap_op  = alu_op;
        instr    = 16'h2222;
        br_taken = ~br_taken;
        #1;
        chk({req, " R11 ctl held mid-cycle"}, 32'(ctl), 32'(snap_ctl));
        chk({req, " R11 alu_op held mid-cycle"}, 32'(alu_op), 32'(snap_op));
        tick();
        chk({req, " R3 wback state"}, 32'(state), 32'd3);
        chk({req, " R5 wback ctl"}, 32'(ctl), 32'(CTL_WBACK));
        chk({req, " R5 waddr"}, 32'(rf_waddr), 32'h3);
        chk({req, " R12 rd_a after stray instr"}, 32'(rf_rd_a), 32'h3);
        tick();
        expect_fetch({req, " R3 return"});
    endtask

    // R6: load
    task automatic t_load();
        instr = 16'h25C0;
        expect_fetch("R6 load");
        tick();
        instr = 16'h3FF0;
        expect_decode("R6 load", 4'h5, 4'hC);
        tick();
        chk("R6 memrd state", 32'(state), 32'd4);
        chk("R6 memrd ctl", 32'(ctl), 32'(CTL_MEMRD));
        chk("R6 memrd addr_sel", 32'(mem_addr_sel), 32'd2);
        chk("R6 memrd waddr", 32'(rf_waddr), 32'h5);
        tick();
        expect_fetch("R6 return");
    endtask

    // R7: store
    task automatic t_store();
        instr = 16'h3720;
        expect_fetch("R7 store");
        tick();
        expect_decode("R7 store", 4'h7, 4'h2);
        tick();
        chk("R7 memwr state", 32'(state), 32'd5);
        chk("R7 memwr ctl", 32'(ctl), 32'(CTL_MEMWR));
        chk("R7 memwr addr_sel", 32'(mem_addr_sel), 32'd1);
        tick();
        expect_fetch("R7 return");
    endtask

    // R8: relative jump
    task automatic t_jump(input string req, input bit taken, input logic [7:0] off,
                          input logic [15:0] exp_sext);
        instr = {4'hB, 4'h4, off};
        br_taken = ~taken;
        expect_fetch(req);
        tick();
        br_taken = taken;
        expect_decode(req, 4'h4, off[7:4]);
        chk({req, " R8 jcond"}, 32'(jcond), 32'h4);
        tick();
        chk({req, " R8 jump state"}, 32'(state), 32'd6);
        chk({req, " R8 jump ctl"}, 32'(ctl), taken ? 32'(CTL_JUMP) : 32'd0);
        chk({req, " R8 offset"}, 32'(ir_sext), 32'(exp_sext));
        br_taken = ~taken;
        #1;
        chk({req, " R8 late br_taken ignored"}, 32'(ip_rel_we), 32'(taken));
        tick();
        expect_fetch({req, " R8 return"});
    endtask

    // R9: no operation and reserved opcodes
    task automatic t_nop(input string req, input logic [15:0] word);
        instr = word;
        expect_fetch(req);
        tick();
        expect_decode(req, word[11:8], word[7:4]);
        tick();
        expect_fetch({req, " R9 back to fetch"});
    endtask

    // R10: halt, then R1 recovery through reset
    task automatic t_halt();
        instr = 16'h1000;
        expect_fetch("R10 halt");
        tick();
        expect_decode("R10 halt", 4'h0, 4'h0);
        tick();
        chk("R10 halt state", 32'(state), 32'd7);
        chk("R10 halt ctl", 32'(ctl), 32'(CTL_HALT));
        for (int i = 0; i < 6; i++) begin
            instr    = 16'h4000 + 16'(i * 16'h1111);
            br_taken = i[0];
            tick();
            chk("R10 stays halted", 32'(state), 32'd7);
            chk("R10 halted strobes", 32'(ctl), 32'(CTL_HALT));
        end
        rst_n = 1'b0;
        #1;
        chk("R1 reset leaves halt", 32'(state), 32'd0);
        chk("R1 halted cleared", 32'(halted), 32'd0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        instr = 16'h0000;
        tick();
        chk("R2 decode after reset", 32'(state), 32'd1);
        tick();
        chk("R9 nop after reset", 32'(state), 32'd0);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #2;
        t_reset();
        t_alu("R3 add",  4'h4, 3'd0, 1'b0, 3'b111);
        t_alu("R3 sub",  4'h5, 3'd1, 1'b0, 3'b111);
        t_alu("R3 xor",  4'h8, 3'd2, 1'b0, 3'b101);
        t_alu("R3 and",  4'h9, 3'd3, 1'b0, 3'b101);
        t_alu("R3 or",   4'hA, 3'd4, 1'b0, 3'b101);
        t_alu("R4 addi", 4'h6, 3'd0, 1'b1, 3'b111);
        t_alu("R4 subi", 4'h7, 3'd1, 1'b1, 3'b111);
        t_load();
        t_store();
        t_jump("R8 taken back",  1'b1, 8'h80, 16'hFF80);
        t_jump("R8 taken fwd",   1'b1, 8'h7F, 16'h007F);
        t_jump("R8 not taken",   1'b0, 8'hF0, 16'hFFF0);
        t_nop("R9 nop",      16'h0ABC);
        t_nop("R9 reserved C", 16'hC123);
        t_nop("R9 reserved F", 16'hF456);
        t_halt();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule